// File: doc/BRIEF.md
# Input Overvoltage Threshold Register (Linear11)

This block holds the input-overvoltage trip point of a power stage. The host writes and reads it as a 16-bit signed Linear11 word. The exponent occupies bits 15:11 and the mantissa bits 10:0, both in two's complement. Internally the threshold is kept as an unsigned count of 0.25 V steps, and the supported band is 16 to 80 counts (4 V to 20 V).

A host write is converted to quarter-volt counts. If it does not land exactly on a supported step inside the band, it is refused: the threshold keeps its old value and a sticky data-error flag is raised. A restore strobe loads a backup word through a second path. That path never refuses a word; it rounds the word to the nearest step and clamps it into the band.

Every sample of the digitized input voltage is compared against the threshold, and the result is held on a registered fault output.

Top module: `l11_ovlim_reg`

## Requirements
- R1: After reset, `rd_word` reads 16'hF050 (exponent 11110b, mantissa 80), and `ov_fault` and `data_err` are 0.
- R2: `rd_word` always carries exponent 11110b in bits 15:11 and the threshold in quarter-volt counts, zero-extended, in bits 10:0.
- R3: A write with exponent E and mantissa M (bits 15:11 and 10:0, two's complement) stands for M·2^(E+2) counts. It is accepted when M ≥ 0, the value is an integer, and it lies in 16..80. The new threshold is visible on `rd_word` one cycle later. With no write and no restore, the threshold does not change.
- R4: A write that fails R3 leaves the threshold unchanged and sets `data_err` on the next cycle.
- R5: `data_err` stays set until a cycle with `err_clr` high. If a rejected write and `err_clr` arrive in the same cycle, the flag is set.
- R6: A restore word decodes as in R3. A negative value becomes 16. A fractional value is rounded to the nearest count, with halves rounded up. The result is then clamped to 16..80. The result is visible one cycle later.
- R7: When `rstr_en` and `wr_en` are high in the same cycle, the restore is applied and the write is ignored, including its error effect.
- R8: In a cycle with `smp_vld` high, `ov_fault` on the next cycle equals (`smp_val` > threshold). The compare is strict and uses the threshold held before that edge.
- R9: In a cycle without `smp_vld`, `ov_fault` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_word | input | 16 | Linear11 word to write |
| rstr_en | input | 1 | Restore strobe |
| rstr_word | input | 16 | Backup Linear11 word |
| err_clr | input | 1 | Clears the data-error flag |
| smp_vld | input | 1 | Voltage sample valid |
| smp_val | input | 8 | Input voltage in 0.25 V counts, unsigned |
| rd_word | output | 16 | Canonical Linear11 readback |
| ov_fault | output | 1 | Input overvoltage fault |
| data_err | output | 1 | Sticky invalid-data flag |

## Verification
Writes are tried at several exponents that encode the same or neighbouring counts. This separates a correct shift in each direction from one that only handles the canonical exponent. Mantissas just outside 16..80, negative mantissas, fractional results and extreme exponents show whether rejection keeps the old threshold and raises the flag.

Restore words with fractions below, at and above one half, together with negative and huge values, separate rounding from truncation and show that clamping works at each end. Samples equal to, one above and one below the threshold tell a strict compare from a non-strict one. A sample taken in the same cycle as a write shows which threshold the compare uses.

// File: rtl/l11_ovlim_pkg.sv
package l11_ovlim_pkg;
    localparam int WORD_W = 16;
    localparam int MAN_W  = 11;
    localparam int EXP_W  = WORD_W - MAN_W;
    // exponent that makes one mantissa step equal one quarter volt
    localparam logic [EXP_W-1:0] CANON_EXP = 5'b11110;
    localparam int DEF_MIN = 16;
    localparam int DEF_MAX = 80;
endpackage

// File: rtl/l11_ovlim_decode.sv
module l11_ovlim_decode
    import l11_ovlim_pkg::*;
#(
    parameter int LIM_MIN = DEF_MIN,
    parameter int LIM_MAX = DEF_MAX,
    parameter int LIM_W   = 7,
    parameter bit SNAP    = 1'b0
) (
    input  logic [WORD_W-1:0] word,
    output logic              ok,
    output logic [LIM_W-1:0]  val
);
    logic              neg;
    logic              right;
    logic              exact;
    logic signed [5:0] sh;
    logic [4:0]        rs;
    logic [31:0]       mag;
    logic [31:0]       scaled;

    // shift relative to the quarter-volt exponent
    always_comb begin
        neg   = word[MAN_W-1];
        mag   = 32'(word[MAN_W-2:0]);
        sh    = $signed({word[WORD_W-1], word[WORD_W-1:MAN_W]}) + 6'sd2;
        right = sh[5];
        rs    = 5'(-sh);
        if (right) begin
            exact  = (mag & ((32'd1 << rs) - 32'd1)) == 32'd0;
            scaled = mag >> rs;
        end else begin
            exact  = 1'b1;
            scaled = mag << sh[4:0];
        end
    end

    generate
        if (SNAP) begin : g_snap
            logic [31:0] half;
            logic [31:0] rnd;
            always_comb begin
                half = (right && rs != 5'd0) ? (32'd1 << (rs - 5'd1)) : 32'd0;
                rnd  = exact ? scaled : ((mag + half) >> rs);
                if (neg || rnd < 32'(LIM_MIN)) begin
                    val = LIM_W'(LIM_MIN);
                end else if (rnd > 32'(LIM_MAX)) begin
                    val = LIM_W'(LIM_MAX);
                end else begin
                    val = rnd[LIM_W-1:0];
                end
            end
            assign ok = 1'b1;
        end else begin : g_strict
            always_comb begin
                ok  = !neg && exact &&
                      (scaled >= 32'(LIM_MIN)) && (scaled <= 32'(LIM_MAX));
                val = scaled[LIM_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/l11_ovlim_cmp.sv
module l11_ovlim_cmp #(
    parameter int SMP_W = 8,
    parameter int LIM_W = 7
) (
    input  logic [SMP_W-1:0] smp,
    input  logic [LIM_W-1:0] lim,
    output logic             gt
);
    always_comb begin
        gt = 32'(smp) > 32'(lim);
    end
endmodule

// File: rtl/l11_ovlim_reg.sv
module l11_ovlim_reg
    import l11_ovlim_pkg::*;
#(
    parameter int LIM_MIN = DEF_MIN,
    parameter int LIM_MAX = DEF_MAX,
    parameter int SMP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rstr_en,
    input  logic [WORD_W-1:0] rstr_word,
    input  logic              err_clr,
    input  logic              smp_vld,
    input  logic [SMP_W-1:0]  smp_val,
    output logic [WORD_W-1:0] rd_word,
    output logic              ov_fault,
    output logic              data_err
);
    localparam int LIM_W = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [LIM_W-1:0] limit;
        logic             fault;
        logic             err;
    } ovlim_st_t;

    ovlim_st_t st_d, st_q;

    logic             wr_ok, snap_ok, gt;
    logic [LIM_W-1:0] wr_val, snap_val;
    logic             wr_bad;

    l11_ovlim_decode #(
        .LIM_MIN(LIM_MIN), .LIM_MAX(LIM_MAX), .LIM_W(LIM_W), .SNAP(1'b0)
    ) u_wr_dec (
        .word(wr_word), .ok(wr_ok), .val(wr_val)
    );

    l11_ovlim_decode #(
        .LIM_MIN(LIM_MIN), .LIM_MAX(LIM_MAX), .LIM_W(LIM_W), .SNAP(1'b1)
    ) u_rs_dec (
        .word(rstr_word), .ok(snap_ok), .val(snap_val)
    );

    l11_ovlim_cmp #(
        .SMP_W(SMP_W), .LIM_W(LIM_W)
    ) u_cmp (
        .smp(smp_val), .lim(st_q.limit), .gt(gt)
    );

    always_comb begin
        st_d   = st_q;
        wr_bad = wr_en && !rstr_en && !wr_ok;
        if (rstr_en) begin
            if (snap_ok) begin
                st_d.limit = snap_val;
            end
        end else if (wr_en && wr_ok) begin
            st_d.limit = wr_val;
        end
        if (err_clr) begin
            st_d.err = 1'b0;
        end
        if (wr_bad) begin
            st_d.err = 1'b1;
        end
        if (smp_vld) begin
            st_d.fault = gt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.limit <= LIM_W'(LIM_MAX);
            st_q.fault <= 1'b0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_word  = {CANON_EXP, MAN_W'(st_q.limit)};
    assign ov_fault = st_q.fault;
    assign data_err = st_q.err;
endmodule

// File: rtl/l11_ovlim_chk.sv
module l11_ovlim_chk #(
    parameter int LIM_MIN = 16,
    parameter int LIM_MAX = 80,
    parameter int SMP_W   = 8,
    parameter int MAN_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rstr_en,
    input logic             err_clr,
    input logic             smp_vld,
    input logic [SMP_W-1:0] smp_val,
    input logic [MAN_W-1:0] rd_man,
    input logic             ov_fault,
    input logic             data_err
);
    assert_limit_in_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_man >= MAN_W'(LIM_MIN)) && (rd_man <= MAN_W'(LIM_MAX)));

    assert_limit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rstr_en) |=> $stable(rd_man));

    assert_restore_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rstr_en |=> (rd_man >= MAN_W'(LIM_MIN)) && (rd_man <= MAN_W'(LIM_MAX)));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_err && !err_clr) |=> data_err);

    assert_err_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_err) |-> $past(err_clr));

    assert_fault_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> (ov_fault == (MAN_W'($past(smp_val)) > $past(rd_man))));

    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(ov_fault));
endmodule

bind l11_ovlim_reg l11_ovlim_chk #(
    .LIM_MIN(LIM_MIN), .LIM_MAX(LIM_MAX), .SMP_W(SMP_W),
    .MAN_W(l11_ovlim_pkg::MAN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rstr_en(rstr_en),
    .err_clr(err_clr), .smp_vld(smp_vld), .smp_val(smp_val),
    .rd_man(rd_word[l11_ovlim_pkg::MAN_W-1:0]),
    .ov_fault(ov_fault), .data_err(data_err)
);

// File: tb/tb_l11_ovlim_reg.sv
`timescale 1ns/1ps
module tb_l11_ovlim_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        rstr_en = 1'b0;
    logic [15:0] rstr_word = '0;
    logic        err_clr = 1'b0;
    logic        smp_vld = 1'b0;
    logic [7:0]  smp_val = '0;
    logic [15:0] rd_word;
    logic        ov_fault, data_err;

    always #2 clk = ~clk;

    l11_ovlim_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .rstr_en(rstr_en), .rstr_word(rstr_word), .err_clr(err_clr),
        .smp_vld(smp_vld), .smp_val(smp_val), .rd_word(rd_word),
        .ov_fault(ov_fault), .data_err(data_err)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;
    int m_lim = 80;
    int m_flt = 0;
    int m_err = 0;

    function automatic logic [15:0] mk(int e, int m);
        return {5'(e), 11'(m)};
    endfunction

    function automatic real qval(logic [15:0] w);
        int e, m;
        e = int'($signed(w[15:11]));
        m = int'($signed(w[10:0]));
        return real'(m) * (2.0 ** (e + 2));
    endfunction

    function automatic bit w_ok(logic [15:0] w);
        real v;
        v = qval(w);
        return ($signed(w[10:0]) >= 0) && (v == $floor(v)) && (v >= 16.0) && (v <= 80.0);
    endfunction

    function automatic int snap(logic [15:0] w);
        real v;
        v = qval(w);
        if (v < 16.0) return 16;
        if (v > 80.0) return 80;
        return int'($floor(v + 0.5));
    endfunction

    task automatic idle();
        wr_en = 0; rstr_en = 0; err_clr = 0; smp_vld = 0;
    endtask

    task automatic chk(string req);
        logic [15:0] exp_rd;
        exp_rd = {5'b11110, 11'(m_lim)};
        vecs++;
        if (rd_word !== exp_rd) begin
            errs++;
            $display("FAIL R2/%s rd_word got %h exp %h", req, rd_word, exp_rd);
        end
        if (ov_fault !== 1'(m_flt)) begin
            errs++;
            $display("FAIL %s ov_fault got %b exp %0d", req, ov_fault, m_flt);
        end
        if (data_err !== 1'(m_err)) begin
            errs++;
            $display("FAIL %s data_err got %b exp %0d", req, data_err, m_err);
        end
    endtask

    // one clock: model updates from the applied inputs, compare at negedge
    task automatic tick(string req);
        bit bad;
        @(posedge clk);
        bad = 0;
        if (smp_vld) m_flt = (int'(smp_val) > m_lim) ? 1 : 0;
        if (rstr_en) m_lim = snap(rstr_word);
        else if (wr_en) begin
            if (w_ok(wr_word)) m_lim = int'(qval(wr_word));
            else bad = 1;
        end
        if (err_clr) m_err = 0;
        if (bad) m_err = 1;
        @(negedge clk);
        chk(req);
        idle();
    endtask

    task automatic wr(int e, int m, string req);
        wr_en = 1; wr_word = mk(e, m); tick(req);
    endtask

    task automatic rs(int e, int m, string req);
        rstr_en = 1; rstr_word = mk(e, m); tick(req);
    endtask

    task automatic smp(int v, string req);
        smp_vld = 1; smp_val = 8'(v); tick(req);
    endtask

    task automatic clr();
        err_clr = 1; tick("R5");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1");
        // R3: equivalent encodings at several exponents
        wr(-2, 40, "R3"); wr(-1, 25, "R3"); wr(0, 5, "R3"); wr(1, 10, "R3");
        wr(-3, 34, "R3"); wr(-2, 16, "R3"); wr(2, 8, "R3");
        tick("R3");
        // R4: rejected writes
        wr(-3, 33, "R4"); tick("R4"); clr();
        wr(-2, 15, "R4"); clr();
        wr(-2, 81, "R4"); clr();
        wr(-2, -40, "R4"); clr();
        wr(15, 1, "R4"); clr();
        wr(-16, 1023, "R4"); clr();
        wr(-4, 0, "R4"); clr();
        // R5: set beats clear, sticky while idle
        wr_en = 1; wr_word = mk(-2, 90); err_clr = 1; tick("R5");
        tick("R5"); tick("R5"); smp(0, "R5"); clr(); tick("R5");
        // R3/R4 sweep of the canonical exponent across the band edges
        for (int m = 0; m < 100; m++) begin
            wr(-2, m, "R3");
            if (data_err) clr();
        end
        // R6: restore rounding and clamping
        rs(-2, -5, "R6"); rs(5, 100, "R6"); rs(-3, 67, "R6"); rs(-4, 69, "R6");
        rs(-2, 0, "R6"); rs(-2, 50, "R6"); rs(-5, 255, "R6"); rs(-3, 161, "R6");
        rs(-3, 31, "R6"); rs(-16, -1, "R6"); rs(-1, 30, "R6");
        // R7: restore wins over a write in the same cycle
        rstr_en = 1; rstr_word = mk(-2, 60); wr_en = 1; wr_word = mk(-2, 30); tick("R7");
        rstr_en = 1; rstr_word = mk(-2, 44); wr_en = 1; wr_word = mk(-2, 5); tick("R7");
        tick("R7");
        // R8: strict compare
        wr(-2, 40, "R8");
        smp(40, "R8"); smp(41, "R8"); smp(39, "R8"); smp(255, "R8"); smp(0, "R8");
        smp(80, "R8");
        // R8: sample in the same cycle as a write uses the old threshold
        smp_vld = 1; smp_val = 8'd30; wr_en = 1; wr_word = mk(-2, 20); tick("R8");
        smp(30, "R8");
        // R9: hold without a valid sample
        smp_val = 8'd0; tick("R9");
        smp_val = 8'd5; tick("R9");
        wr(-2, 80, "R9");
        smp(10, "R9");
        smp_val = 8'd255; tick("R9"); tick("R9");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule